// File: doc/BRIEF.md
# Grant-Passing Priority Bus Arbiter

This block decides which of several would-be masters owns a shared multipoint bus. Every device drives its own request, and the OR of those requests forms one common request line toward a central controller. The controller does not hold a line per device. It drives a single grant into the head of a chain of slots. Each slot either passes the grant on or, if its device is asking for the bus, keeps the grant and claims ownership. Priority therefore comes only from a slot's position in the chain. Slot 0 sits at the head and outranks every slot behind it.

A slot that captures the grant sets its master flag. The OR of all master flags is the shared busy line. The controller watches that line. It withdraws the grant once it sees the bus owned. After the owner releases, the controller waits one full idle cycle before it offers a new grant. Requests that lost stay pending and are served by later grants, in chain order.

The number of slots is a parameter. Reset is synchronous and active high.

Top module: `gpb_arbiter`

## Requirements
- R1: `bus_req` is high in exactly those cycles in which at least one bit of `dev_req` is high (combinational OR).
- R2: `grant_head` is a register output. It is set at a clock edge only if, just before that edge, `bus_req` is high, `bus_busy` is low, and `bus_busy` was also low in the cycle before. While it is high, a low `bus_req` with `bus_busy` low clears it at the next edge.
- R3: Bit i of `grant_taps` is the grant leaving slot i. It equals the grant entering slot i (`grant_head` for slot 0, bit i-1 of `grant_taps` otherwise) ANDed with the inverse of `dev_req[i]`. A requesting slot blocks the grant and a silent slot passes it on.
- R4: A slot whose grant input is high, whose request is high and for which `bus_busy` is low sets its bit of `dev_master` at the next edge. `bus_busy` is the OR of `dev_master`.
- R5: A slot keeps its `dev_master` bit for as long as its request stays high, and a request from any other slot cannot take ownership away. When the request drops, the bit clears at the next edge.
- R6: After `bus_busy` falls, `grant_head` stays low for that cycle and the next one. It can rise no earlier than the second edge after the fall.
- R7: Any cycle with `bus_busy` high is followed by a cycle with `grant_head` low.
- R8: When several slots request together, only the lowest-index requester becomes master. The others keep waiting and are each granted in index order once the bus frees.
- R9: At most one bit of `dev_master` is high in any cycle.
- R10: A high `rst` at a clock edge clears `dev_master`, `bus_busy` and `grant_head`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_req | input | NUM_SLOTS | Per-slot bus request, bit 0 highest priority |
| bus_req | output | 1 | Common request line (OR of requests) |
| grant_head | output | 1 | Grant the controller drives into the head of the chain |
| grant_taps | output | NUM_SLOTS | Grant leaving each slot |
| bus_busy | output | 1 | Shared busy line |
| dev_master | output | NUM_SLOTS | Per-slot ownership flag |

## Verification
The bench targets the edges around ownership changes. It raises a higher-priority request while the bus is owned; a design that let a grant still travelling in the chain reach it would end up with two masters, or would preempt the owner. It releases the bus while others are waiting and counts the idle cycles before the next grant; a controller without the hold-off cycle would grant one cycle early. It presents simultaneous request patterns, withdraws requests before the grant arrives, and resets in the middle of ownership. A chain with wrong ordering would serve a higher index first, and a slot that ignored its own request would pass the grant on to the slot behind it.

// File: rtl/gpb_arbiter_pkg.sv
package gpb_arbiter_pkg;

   localparam int unsigned GPB_MAX_SLOTS = 64;

   typedef enum logic [1:0] {
      CTL_IDLE  = 2'd0,
      CTL_OFFER = 2'd1,
      CTL_OWNED = 2'd2,
      CTL_SETTLE = 2'd3
   } gpb_ctl_e;

endpackage

// File: rtl/gpb_grant_ctrl.sv
module gpb_grant_ctrl
   import gpb_arbiter_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic req_any,
   input  logic busy,
   output logic grant
);

   gpb_ctl_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         CTL_IDLE:   if (req_any && !busy) state_d = CTL_OFFER;
         CTL_OFFER: begin
            if (busy)          state_d = CTL_OWNED;
            else if (!req_any) state_d = CTL_IDLE;
         end
         CTL_OWNED:  if (!busy) state_d = CTL_SETTLE;
         CTL_SETTLE: state_d = req_any ? CTL_OFFER : CTL_IDLE;
         default:    state_d = CTL_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= CTL_IDLE;
      else     state_q <= state_d;
   end

   assign grant = (state_q == CTL_OFFER);

   AST_GRANT_WITHDRAWN: assert property (@(posedge clk) disable iff (rst)
      busy |=> !grant); // R7

   AST_HOLDOFF_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |=> !grant); // R6

   AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
      $rose(grant) |-> $past(req_any)); // R2

endmodule

// File: rtl/gpb_chain_slot.sv
module gpb_chain_slot (
   input  logic clk,
   input  logic rst,
   input  logic req,
   input  logic grant_in,
   input  logic busy_in,
   output logic grant_out,
   output logic master
);

   logic master_q;

   assign grant_out = grant_in & ~req;

   always_ff @(posedge clk) begin
      if (rst)           master_q <= 1'b0;
      else if (master_q) master_q <= req;
      else               master_q <= grant_in & req & ~busy_in;
   end

   assign master = master_q;

   AST_RELEASE_NEXT_EDGE: assert property (@(posedge clk) disable iff (rst)
      (master_q && !req) |=> !master_q); // R5

   AST_HOLD_WHILE_REQ: assert property (@(posedge clk) disable iff (rst)
      (master_q && req) |=> master_q); // R5

   AST_NO_CAPTURE_WITHOUT_GRANT: assert property (@(posedge clk) disable iff (rst)
      (!master_q && !grant_in) |=> !master_q); // R4

   AST_CAPTURE_ON_GRANT: assert property (@(posedge clk) disable iff (rst)
      (grant_in && req && !busy_in) |=> master_q); // R4

endmodule

// File: rtl/gpb_arbiter.sv
module gpb_arbiter
   import gpb_arbiter_pkg::*;
#(
   parameter int unsigned NUM_SLOTS = 4
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NUM_SLOTS-1:0] dev_req,
   output logic                 bus_req,
   output logic                 grant_head,
   output logic [NUM_SLOTS-1:0] grant_taps,
   output logic                 bus_busy,
   output logic [NUM_SLOTS-1:0] dev_master
);

   if (NUM_SLOTS < 1 || NUM_SLOTS > GPB_MAX_SLOTS) begin : g_bad_slots
      $error("gpb_arbiter: NUM_SLOTS out of range");
   end

   logic [NUM_SLOTS:0] chain;

   assign bus_req  = |dev_req;
   assign bus_busy = |dev_master;

   gpb_grant_ctrl u_ctrl (
      .clk     (clk),
      .rst     (rst),
      .req_any (bus_req),
      .busy    (bus_busy),
      .grant   (grant_head)
   );

   assign chain[0] = grant_head;

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      gpb_chain_slot u_slot (
         .clk       (clk),
         .rst       (rst),
         .req       (dev_req[i]),
         .grant_in  (chain[i]),
         .busy_in   (bus_busy),
         .grant_out (chain[i+1]),
         .master    (dev_master[i])
      );

      if (i > 0) begin : g_prio_chk
         AST_LOWEST_INDEX_WINS: assert property (@(posedge clk) disable iff (rst)
            $rose(dev_master[i]) |-> ($past(dev_req[i-1:0]) == '0)); // R8
      end
   end

   assign grant_taps = chain[NUM_SLOTS:1];

   AST_SINGLE_MASTER: assert property (@(posedge clk) disable iff (rst)
      $onehot0(dev_master)); // R9

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (dev_master == '0 && !grant_head)); // R10

endmodule

// File: tb/gpb_arbiter_test.sv
module gpb_arbiter_test;

   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [N-1:0] dev_req = '0;
   logic         bus_req, grant_head, bus_busy;
   logic [N-1:0] grant_taps, dev_master;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // reference state
   bit m_grant = 1'b0;
   bit m_busy_prev = 1'b0;
   int m_owner = -1;

   always #4 clk = ~clk;

   gpb_arbiter #(.NUM_SLOTS(N)) uut (
      .clk        (clk),
      .rst        (rst),
      .dev_req    (dev_req),
      .bus_req    (bus_req),
      .grant_head (grant_head),
      .grant_taps (grant_taps),
      .bus_busy   (bus_busy),
      .dev_master (dev_master)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all(input logic [N-1:0] r);
      logic [N-1:0] exp_taps;
      logic [N-1:0] exp_master;
      logic g;
      g = m_grant;
      for (int i = 0; i < N; i++) begin
         exp_taps[i] = g & ~r[i];
         g = exp_taps[i];
      end
      exp_master = (m_owner >= 0) ? (N'(1) << m_owner) : '0;
      chk("R1 bus_req", {31'd0, bus_req}, {31'd0, (r != '0)});
      chk("R2 grant_head", {31'd0, grant_head}, {31'd0, m_grant});
      chk("R3 grant_taps", 32'(grant_taps), 32'(exp_taps));
      chk("R4 dev_master", 32'(dev_master), 32'(exp_master));
      chk("R4 bus_busy", {31'd0, bus_busy}, {31'd0, (m_owner >= 0)});
      chk("R9 one master", {31'd0, $countones(dev_master) <= 1}, 32'd1);
   endtask

   task automatic advance(input logic [N-1:0] r);
      bit busy_now;
      bit next_grant;
      busy_now = (m_owner >= 0);
      next_grant = (r != '0) && !busy_now && !m_busy_prev;
      if (m_owner >= 0) begin
         if (!r[m_owner]) m_owner = -1;
      end else if (m_grant) begin
         for (int i = N - 1; i >= 0; i--) if (r[i]) m_owner = i;
      end
      m_busy_prev = busy_now;
      m_grant = next_grant;
   endtask

   task automatic step(input logic [N-1:0] r);
      @(negedge clk);
      dev_req = r;
      #1;
      compare_all(r);
      advance(r);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      dev_req = '0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      m_grant = 1'b0;
      m_busy_prev = 1'b0;
      m_owner = -1;
      #1;
      chk("R10 master after reset", 32'(dev_master), 32'd0);
      chk("R10 busy after reset", {31'd0, bus_busy}, 32'd0);
      chk("R10 grant after reset", {31'd0, grant_head}, 32'd0);
   endtask

   initial begin
      do_reset();

      // single requester, hold, release
      step(4'b0100);
      step(4'b0100);
      step(4'b0100);
      chk("R4 slot2 owns", 32'(dev_master), 32'h4);
      // higher priority arrives during ownership: no preemption
      step(4'b0110);
      step(4'b0110);
      chk("R5 owner kept", 32'(dev_master), 32'h4);
      // release, slot1 waits through hold-off
      step(4'b0010);
      step(4'b0010);
      chk("R6 no grant on release cycle", {31'd0, grant_head}, 32'd0);
      step(4'b0010);
      chk("R6 no grant one cycle later", {31'd0, grant_head}, 32'd0);
      step(4'b0010);
      chk("R6 grant after hold-off", {31'd0, grant_head}, 32'd1);
      step(4'b0010);
      chk("R5 slot1 took over", 32'(dev_master), 32'h2);
      step(4'b0010);
      chk("R7 grant dropped", {31'd0, grant_head}, 32'd0);
      step(4'b0000);
      step(4'b0000);
      step(4'b0000);

      // simultaneous requests, served in index order
      step(4'b1011);
      step(4'b1011);
      step(4'b1011);
      chk("R8 lowest index wins", 32'(dev_master), 32'h1);
      for (int k = 0; k < 5; k++) step(4'b1010);
      chk("R8 next in order", 32'(dev_master), 32'h2);
      for (int k = 0; k < 5; k++) step(4'b1000);
      chk("R8 last in order", 32'(dev_master), 32'h8);
      step(4'b0000);
      step(4'b0000);
      step(4'b0000);

      // request withdrawn before capture
      step(4'b0001);
      step(4'b0000);
      step(4'b0000);
      chk("R2 withdrawn request no owner", 32'(dev_master), 32'h0);

      // all slots together
      for (int k = 0; k < 4; k++) step(4'b1111);
      chk("R8 all request slot0", 32'(dev_master), 32'h1);
      chk("R3 grant blocked at slot0", 32'(grant_taps), 32'h0);

      // reset in the middle of ownership
      do_reset();
      step(4'b0000);

      // patterned sweep
      for (int k = 0; k < 200; k++) step(N'((k * 7 + k / 3) % 16));
      for (int k = 0; k < 6; k++) step(4'b0000);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule